// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a two-wire serial slave that lets a host read and write a small bank of 8-bit control registers. The lines are open-drain, so the block sees each line as an input and pulls SDA low through an output-enable. Both lines pass through a synchronizer into the system clock domain. START and STOP are found from SDA edges while SCL is high. A protocol state machine then steps through the address, the command code, an optional count, and the data bytes.

The command code picks the access mode. With its top bit set, the low seven bits give the offset of a single register (indexed byte access). With the top bit clear, the transfer is a block transfer that starts at offset 0 and walks upward one register per byte. A block transfer carries a byte-count phase, which the `cnt_skip` input suppresses. The host may end a transfer after any complete byte. The registers reset to values taken from a parameter, so the chip runs with them untouched. Every completed register write is also shown on a write-event port, so logic outside the block can observe it.

States: `S_IDLE` (bus free or transfer abandoned), `S_ADDR` (shift address byte), `S_ADDR_ACK` (acknowledge own address), `S_CMD`/`S_CMD_ACK` (command byte), `S_CNT`/`S_CNT_ACK` (incoming count byte of a block write), `S_WR`/`S_WR_ACK` (data byte into a register), `S_RD` (shift a byte out), and `S_RD_ACK` (sample the host's acknowledge). The transitions are as follows:
- STOP leads from any state to `S_IDLE`, and START leads from any state to `S_ADDR`.
- A matching address leads to `S_ADDR_ACK`. A non-matching address leads to `S_IDLE`.
- `S_ADDR_ACK` leads to `S_RD` for a read and to `S_CMD` for a write.
- `S_CMD_ACK` leads to `S_CNT` for a block access whose count is not suppressed, and to `S_WR` otherwise.
- `S_CNT_ACK` and `S_WR_ACK` lead to `S_WR`.
- `S_RD_ACK` leads to `S_RD` on an acknowledge and to `S_IDLE` on a not-acknowledge.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges the address byte D2h (write) or D3h (read), and then every byte it receives during a write. For any other address byte it never drives SDA until the next START.
- R2: A write whose command code has bit 7 = 1 stores the following data byte in the register whose offset is command bits 6:0. It also pulses `wr_stb` for one cycle, with `wr_idx`/`wr_val` giving that offset and byte.
- R3: A byte read (command bit 7 = 1, repeated START, address D3h) returns the register at offset bits 6:0, most significant bit first.
- R4: A block write (command bit 7 = 0) with `cnt_skip` = 0 treats the first byte after the command as a count, which is acknowledged and not stored. The bytes after it go to offsets 0, 1, 2 and upward in turn.
- R5: A block write with `cnt_skip` = 1 stores the first byte after the command in offset 0, the next in offset 1, and so on.
- R6: A block read with `cnt_skip` = 0 returns the count NUM_REGS first, then the registers from offset 0 upward.
- R7: A block read with `cnt_skip` = 1 returns the register at offset 0 first, then the higher offsets in order.
- R8: A not-acknowledge from the host after a read byte ends the transfer. The slave then leaves SDA released through any further SCL pulses until the next START.
- R9: A STOP at any point returns the slave to idle. A byte cut short is not written, and bytes completed earlier in the same transfer keep their new values.
- R10: After reset, SDA is released and register i holds 11h·(i+1) with the default parameters, i.e. 11h, 22h, … 88h.
- R11: A write to an offset at or above NUM_REGS is acknowledged but changes no register and gives no `wr_stb`. A read from such an offset returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cnt_skip | input | 1 | Suppress the byte-count phase of block transfers |
| wr_stb | output | 1 | One-cycle pulse on each register write |
| wr_idx | output | 7 | Offset of the register written |
| wr_val | output | 8 | Byte written |
| regs_o | output | NUM_REGS*8 | Current register contents, offset i in bits 8i+7:8i |

## Verification
A wrong state in the protocol machine shows at the ports within one byte time. It appears as one of three faults: a missing or extra acknowledge on the ninth clock, a data bit on SDA out of order, or a `wr_stb` at the wrong offset. A wrong block pointer or count flag shows on the first byte of the next block transfer, as a shifted read stream or a register written one place off. A fault in STOP handling shows only on a later transfer, as a register changed by a truncated byte or a slave that still drives SDA after the bus should be free. For this reason each abandoned transfer is followed by reads of the neighbouring registers.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 7;
    localparam int BCNT_W = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_CNT,
        S_CNT_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;
    logic            scl_now, scl_old, sda_now, sda_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        scl_now   = scl_sh[STAGES-1];
        scl_old   = scl_sh[STAGES];
        sda_now   = sda_sh[STAGES-1];
        sda_old   = sda_sh[STAGES];
        sda_s     = sda_now;
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        start_det = scl_now & scl_old & sda_old & ~sda_now;
        stop_det  = scl_now & scl_old & ~sda_old & sda_now;
    end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_slave_pkg::*;
#(
    parameter int                     NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0]  REG_INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [OFS_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_val,
    input  logic [OFS_W-1:0]         rd_idx,
    output logic [BYTE_W-1:0]        rd_byte,
    output logic [NUM_REGS*8-1:0]    regs_flat
);
    localparam int NW = OFS_W + 1;
    localparam logic [NW-1:0] NREG_V = NW'(NUM_REGS);

    logic [BYTE_W-1:0] mem_q [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= REG_INIT[gi*8 +: 8];
            end else if (wr_en && wr_idx == OFS_W'(gi)) begin
                mem_q[gi] <= wr_val;
            end
        end
        assign regs_flat[gi*8 +: 8] = mem_q[gi];
    end

    always_comb begin
        rd_byte = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == OFS_W'(i)) rd_byte = mem_q[i];
        end
    end

    // R11
    oob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= NREG_V)) |=> $stable(regs_flat));
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_slave_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_s,
    input  logic               cnt_skip,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic [OFS_W-1:0]   rd_idx,
    output logic               sda_oe,
    output logic               wr_stb,
    output logic [OFS_W-1:0]   wr_idx,
    output logic [BYTE_W-1:0]  wr_val
);
    localparam int NW = OFS_W + 1;
    localparam logic [NW-1:0]     NREG_V  = NW'(NUM_REGS);
    localparam logic [BYTE_W-1:0] CNT_VAL = BYTE_W'(NUM_REGS);

    smb_state_e          state_q, state_d;
    logic [BYTE_W-1:0]   shreg_q;
    logic [BYTE_W-1:0]   tx_q;
    logic [BCNT_W-1:0]   bitcnt_q;
    logic [OFS_W-1:0]    ptr_q;
    logic                rnw_q, blk_q, cnt_pend_q;
    logic                byte_done, addr_hit, send_cnt, ptr_ok;
    logic [BYTE_W-1:0]   tx_next;

    always_comb begin
        byte_done = (bitcnt_q == BCNT_W'(8));
        addr_hit  = (shreg_q[7:1] == DEV_ADDR);
        send_cnt  = blk_q && cnt_pend_q && !cnt_skip;
        tx_next   = send_cnt ? CNT_VAL : rd_byte;
        ptr_ok    = ({1'b0, ptr_q} < NREG_V);
        rd_idx    = ptr_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = S_IDLE;
        end else if (start_det) begin
            state_d = S_ADDR;
        end else if (scl_fall) begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_ADDR:     if (byte_done) state_d = addr_hit ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK: state_d = rnw_q ? S_RD : S_CMD;
                S_CMD:      if (byte_done) state_d = S_CMD_ACK;
                S_CMD_ACK:  state_d = (blk_q && !cnt_skip) ? S_CNT : S_WR;
                S_CNT:      if (byte_done) state_d = S_CNT_ACK;
                S_CNT_ACK:  state_d = S_WR;
                S_WR:       if (byte_done) state_d = S_WR_ACK;
                S_WR_ACK:   state_d = S_WR;
                S_RD:       if (byte_done) state_d = S_RD_ACK;
                S_RD_ACK:   state_d = S_RD;
                default:    state_d = S_IDLE;
            endcase
        end else if (scl_rise && state_q == S_RD_ACK && sda_s) begin
            state_d = S_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            wr_stb     <= 1'b0;
            wr_idx     <= '0;
            wr_val     <= '0;
            shreg_q    <= '0;
            tx_q       <= '0;
            bitcnt_q   <= '0;
            ptr_q      <= '0;
            rnw_q      <= 1'b0;
            blk_q      <= 1'b0;
            cnt_pend_q <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_det || start_det) begin
                sda_oe   <= 1'b0;
                bitcnt_q <= '0;
            end else begin
                if (scl_rise) begin
                    case (state_q)
                        S_ADDR, S_CMD, S_CNT, S_WR: begin
                            shreg_q  <= {shreg_q[6:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        S_RD:    bitcnt_q <= bitcnt_q + 1'b1;
                        default: ;
                    endcase
                end
                if (scl_fall) begin
                    case (state_q)
                        S_ADDR: if (byte_done) begin
                            bitcnt_q <= '0;
                            if (addr_hit) begin
                                sda_oe <= 1'b1;
                                rnw_q  <= shreg_q[0];
                            end
                        end
                        S_CMD: if (byte_done) begin
                            bitcnt_q   <= '0;
                            sda_oe     <= 1'b1;
                            blk_q      <= ~shreg_q[7];
                            cnt_pend_q <= ~shreg_q[7];
                            ptr_q      <= shreg_q[7] ? shreg_q[6:0] : '0;
                        end
                        S_CNT: if (byte_done) begin
                            bitcnt_q   <= '0;
                            sda_oe     <= 1'b1;
                            cnt_pend_q <= 1'b0;
                        end
                        S_WR: if (byte_done) begin
                            bitcnt_q <= '0;
                            sda_oe   <= 1'b1;
                            wr_stb   <= ptr_ok;
                            wr_idx   <= ptr_q;
                            wr_val   <= shreg_q;
                            ptr_q    <= ptr_q + 1'b1;
                        end
                        S_ADDR_ACK: begin
                            if (rnw_q) begin
                                tx_q   <= tx_next;
                                sda_oe <= ~tx_next[7];
                                if (send_cnt) cnt_pend_q <= 1'b0;
                                else          ptr_q <= ptr_q + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        S_CMD_ACK, S_CNT_ACK, S_WR_ACK: sda_oe <= 1'b0;
                        S_RD: begin
                            if (byte_done) begin
                                bitcnt_q <= '0;
                                sda_oe   <= 1'b0;
                            end else begin
                                tx_q   <= {tx_q[6:0], 1'b0};
                                sda_oe <= ~tx_q[6];
                            end
                        end
                        S_RD_ACK: begin
                            tx_q   <= tx_next;
                            sda_oe <= ~tx_next[7];
                            if (send_cnt) cnt_pend_q <= 1'b0;
                            else          ptr_q <= ptr_q + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R1
    addr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR_ACK) |-> sda_oe);

    // R8
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !sda_oe);

    // R9
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == S_IDLE));

    // R2
    wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state_q == S_WR_ACK && sda_oe));
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_slave_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [6:0]            DEV_ADDR = 7'h69,
    parameter logic [NUM_REGS*8-1:0] REG_INIT = 64'h8877_6655_4433_2211
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic                   cnt_skip,
    output logic                   wr_stb,
    output logic [OFS_W-1:0]       wr_idx,
    output logic [BYTE_W-1:0]      wr_val,
    output logic [NUM_REGS*8-1:0]  regs_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [OFS_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_byte;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_proto_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .cnt_skip  (cnt_skip),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val)
    );

    smb_regbank #(.NUM_REGS(NUM_REGS), .REG_INIT(REG_INIT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_stb),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .rd_idx    (rd_idx),
        .rd_byte   (rd_byte),
        .regs_flat (regs_o)
    );
endmodule

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 8;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic cnt_skip = 1'b0;
    logic sda_bus;
    logic sda_oe, wr_stb;
    logic [6:0] wr_idx;
    logic [7:0] wr_val;
    logic [NREG*8-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0]  model [NREG];
    logic [14:0] exp_q [$];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .cnt_skip(cnt_skip), .wr_stb(wr_stb),
        .wr_idx(wr_idx), .wr_val(wr_val), .regs_o(regs_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares each write event against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 R4 R5 unexpected write actual=%h expected=none", {wr_idx, wr_val});
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                if ({wr_idx, wr_val} !== e) begin
                    errors++;
                    $display("FAIL R2 R4 R5 write event actual=%h expected=%h", {wr_idx, wr_val}, e);
                end
            end
        end
    end

    task automatic expect_wr(input int idx, input logic [7:0] v);
        exp_q.push_back({7'(idx), v});
        model[idx] = v;
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
        ack = ~sda_bus;
        wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_q(); scl_m = 1'b1; wait_q();
            b = {b[6:0], sda_bus};
            wait_q(); scl_m = 1'b0;
        end
        wait_q(); sda_m = nack; wait_q(); scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q(); sda_m = 1'b1;
    endtask

    task automatic put(input string req, input logic [7:0] b, input logic exp_ack);
        logic a;
        send_byte(b, a);
        check(req, {31'b0, a}, {31'b0, exp_ack});
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] v);
        bus_start();
        put("R1 addr ack", 8'hD2, 1'b1);
        put("R1 cmd ack", {1'b1, off}, 1'b1);
        put("R1 data ack", v, 1'b1);
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] v);
        bus_start();
        put("R1 addr ack", 8'hD2, 1'b1);
        put("R1 cmd ack", {1'b1, off}, 1'b1);
        bus_start();
        put("R1 read addr ack", 8'hD3, 1'b1);
        recv_byte(1'b1, v);
        bus_stop();
    endtask

    task automatic block_read_open();
        bus_start();
        put("R1 addr ack", 8'hD2, 1'b1);
        put("R1 cmd ack", 8'h00, 1'b1);
        bus_start();
        put("R1 read addr ack", 8'hD3, 1'b1);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++) check(req, {24'b0, regs_o[i*8 +: 8]}, {24'b0, model[i]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) model[i] = 8'(8'h11 * (i + 1));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 reset state
        check("R10 sda_oe", {31'b0, sda_oe}, 32'd0);
        check_regs("R10 reset regs");

        // R1 foreign address: no ack, following bytes ignored
        bus_start();
        put("R1 foreign addr", 8'hA0, 1'b0);
        put("R1 foreign cmd", 8'h83, 1'b0);
        put("R1 foreign data", 8'h5A, 1'b0);
        bus_stop();
        check_regs("R1 regs untouched");

        // R2 byte write
        expect_wr(3, 8'hA5);
        byte_write(7'd3, 8'hA5);
        check_regs("R2 byte write");

        // R3 byte read
        byte_read(7'd3, v);
        check("R3 read off3", {24'b0, v}, {24'b0, model[3]});
        byte_read(7'd6, v);
        check("R3 read off6", {24'b0, v}, {24'b0, model[6]});

        // R4 block write with count
        cnt_skip = 1'b0;
        expect_wr(0, 8'h10); expect_wr(1, 8'h20); expect_wr(2, 8'h30);
        bus_start();
        put("R4 addr", 8'hD2, 1'b1);
        put("R4 cmd", 8'h00, 1'b1);
        put("R4 count", 8'h03, 1'b1);
        put("R4 d0", 8'h10, 1'b1);
        put("R4 d1", 8'h20, 1'b1);
        put("R4 d2", 8'h30, 1'b1);
        bus_stop();
        check_regs("R4 block write");

        // R5 block write without count
        cnt_skip = 1'b1;
        expect_wr(0, 8'hC1); expect_wr(1, 8'hC2);
        bus_start();
        put("R5 addr", 8'hD2, 1'b1);
        put("R5 cmd", 8'h00, 1'b1);
        put("R5 d0", 8'hC1, 1'b1);
        put("R5 d1", 8'hC2, 1'b1);
        bus_stop();
        check_regs("R5 block write");

        // R6 block read with count
        cnt_skip = 1'b0;
        block_read_open();
        recv_byte(1'b0, v);
        check("R6 count byte", {24'b0, v}, NREG);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i == 3, v);
            check("R6 block data", {24'b0, v}, {24'b0, model[i]});
        end
        bus_stop();

        // R7 block read without count, then R8 release after nack
        cnt_skip = 1'b1;
        block_read_open();
        for (int i = 0; i < 3; i++) begin
            recv_byte(i == 2, v);
            check("R7 block data", {24'b0, v}, {24'b0, model[i]});
        end
        begin
            int drove;
            drove = 0;
            for (int k = 0; k < 9; k++) begin
                wait_q(); scl_m = 1'b1; if (sda_oe) drove++; wait_q();
                if (sda_oe) drove++;
                scl_m = 1'b0; wait_q(); if (sda_oe) drove++;
            end
            check("R8 released after nack", drove, 0);
        end
        bus_stop();

        // R9 stop mid-byte in byte write
        bus_start();
        put("R9 addr", 8'hD2, 1'b1);
        put("R9 cmd", 8'h85, 1'b1);
        send_bits(8'hEE, 4);
        bus_stop();
        check("R9 partial byte dropped", {24'b0, regs_o[5*8 +: 8]}, {24'b0, model[5]});

        // R9 stop mid-byte in block write keeps earlier byte
        expect_wr(0, 8'h77);
        bus_start();
        put("R9 addr", 8'hD2, 1'b1);
        put("R9 cmd", 8'h00, 1'b1);
        put("R9 d0", 8'h77, 1'b1);
        send_bits(8'h99, 5);
        bus_stop();
        check_regs("R9 block abandoned");

        // R11 out-of-range offset
        byte_write(7'h40, 8'h3C);
        check_regs("R11 oob write dropped");
        byte_read(7'h40, v);
        check("R11 oob read", {24'b0, v}, 32'h0000_00FF);
        byte_read(7'd1, v);
        check("R11 neighbour intact", {24'b0, v}, {24'b0, model[1]});

        repeat (20) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule